// File: doc/BRIEF.md
# Daisy-Chainable 16-Bit Serial Slave Front End

This block is the serial receive and transmit front end of a port-expander peripheral. It runs on a fast system clock. The external serial clock, the active-low chip select and the data input are brought into that clock domain through synchronisers. While chip select is low, each rising serial-clock edge shifts one data bit into a 16-bit word. When chip select returns high, the block presents the most recent 16 bits as one transaction, split into a command byte and a data byte, together with a one-cycle strobe.

The serial output follows the top bit of the shift register and changes only on falling serial-clock edges. A bit therefore leaves the block fifteen and a half serial-clock periods after it entered. Several devices can be cascaded on one chip select in this way, or the host can read back what it shifted in. If a transaction sets the read flag in its command byte, the next frame starts by replacing the low half of the shift register with a readback byte supplied by the core. That byte then travels out on the serial output.

The system clock must be fast enough that every serial-clock phase and every chip-select high time spans at least three system-clock cycles.

Top module: `spi_chain_slave`

## Requirements
- R1: Reset is synchronous and active low. After reset, dout is 0, frame_valid is 0, and frame_cmd and frame_data are 0x00.
- R2: While chip select is low, each rising edge of sclk shifts din into bit 0 of the 16-bit word. The older bits move one place toward bit 15, so the first bit of a 16-bit frame ends up in bit 15.
- R3: While cs_n is high, sclk and din toggles have no effect. The word and dout stay unchanged, and a following frame with no clock edges latches the same word again.
- R4: Each rising edge of cs_n produces exactly one frame_valid pulse, one system-clock cycle long. In that cycle frame_cmd holds word bits 15..8 and frame_data holds word bits 7..0.
- R5: A frame longer than 16 bits latches only the last 16 bits received. A frame shorter than 16 bits latches the earlier bits shifted up, and its upper bits keep values from the previous frames.
- R6: On each falling sclk edge while chip select is low, dout takes the current bit 15 of the word. A din bit therefore appears on dout 15.5 sclk periods after it is sampled.
- R7: dout is always driven to 0 or 1. It does not change while cs_n is high.
- R8: If bit 7 of frame_cmd (word bit 15) is 1 in a latched frame, then at the falling edge of cs_n that starts the next frame, word bits 7..0 are replaced by rd_byte. Bits 15..8 are not changed. If that bit is 0, the word is kept as it is.
- R9: frame_cmd and frame_data change only in a cycle where frame_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| cs_n | input | 1 | Active-low chip select, asynchronous to clk |
| din | input | 1 | Serial data in, sampled on rising sclk |
| rd_byte | input | 8 | Byte loaded into the word's low half after a read-flagged frame |
| dout | output | 1 | Serial data out, updated on falling sclk |
| frame_valid | output | 1 | One-cycle strobe after cs_n rises |
| frame_cmd | output | 8 | Latched word bits 15..8 |
| frame_data | output | 8 | Latched word bits 7..0 |

## Verification
The hardest case to reach from the ports is the readback load, because it depends on the previous frame. A read-flagged frame has to be latched first, and then the next falling edge of chip select has to merge rd_byte into a word whose upper byte is left over from earlier frames. The stimulus reaches this case in two ways. Directed frames set the read flag and follow it with a short 8-bit frame, so the loaded byte becomes the latched command. Random frame lengths from 0 to 24 bits, with random rd_byte values, then mix this load with stale upper bits and with frames long enough to push the loaded byte out. Sequences with serial-clock edges while chip select is high, followed by an empty frame, show that the word was not touched.

// File: rtl/spi_chain_pkg.sv
// Shared types for the chainable serial slave front end.
// Assumes a byte-wide command and a byte-wide data field in one word.
package spi_chain_pkg;
    localparam int unsigned SPI_BYTE_W = 8;
    localparam int unsigned SPI_WORD_W = 2 * SPI_BYTE_W;

    typedef logic [SPI_BYTE_W-1:0] spi_byte_t;

    typedef struct packed {
        spi_byte_t cmd;
        spi_byte_t data;
    } spi_word_t;
endpackage

// File: rtl/sync_chain.sv
// Multi-flop level synchroniser, one independent chain per lane.
// Assumes each input is held long enough to be seen by several clk edges.
module sync_chain #(
    parameter int unsigned             LANES     = 3,
    parameter int unsigned             STAGES    = 2,
    parameter logic [LANES-1:0]        RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] async_in,
    output logic [LANES-1:0] sync_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES-1:0] chain;

        // Shift the raw input through STAGES flops toward sync_out.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RESET_VAL[g]}};
            end else begin
                chain <= {chain[STAGES-2:0], async_in[g]};
            end
        end

        assign sync_out[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/edge_detect.sv
// Rising and falling edge pulses for synchronised levels.
// Assumes inputs are already in the clk domain.
module edge_detect #(
    parameter int unsigned      LANES     = 2,
    parameter logic [LANES-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] level,
    output logic [LANES-1:0] rise,
    output logic [LANES-1:0] fall
);
    logic [LANES-1:0] level_q;

    // Remember last cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= RESET_VAL;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
    assign fall = ~level & level_q;
endmodule

// File: rtl/shift_core.sv
// Serial word shifter with falling-edge data out and readback byte load.
// Assumes shift and load events never coincide with each other.
module shift_core
    import spi_chain_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_active,
    input  logic      sclk_rise,
    input  logic      sclk_fall,
    input  logic      cs_fall,
    input  logic      din_s,
    input  logic      load_en,
    input  spi_byte_t load_byte,
    output spi_word_t word,
    output logic      dout
);
    // Shift on rising serial clock, or merge the readback byte at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (cs_fall && load_en) begin
            word.data <= load_byte;
        end else if (cs_active && sclk_rise) begin
            word <= {word[SPI_WORD_W-2:0], din_s};
        end
    end

    // Present the top bit on each falling serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 1'b0;
        end else if (cs_active && sclk_fall) begin
            dout <= word[SPI_WORD_W-1];
        end
    end
endmodule

// File: rtl/frame_latch.sv
// Captures the word on frame end, pulses a strobe, tracks a pending read.
// Assumes cs_rise and cs_fall are single-cycle pulses.
module frame_latch
    import spi_chain_pkg::*;
#(
    parameter int unsigned READ_FLAG_BIT = SPI_BYTE_W - 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_rise,
    input  logic      cs_fall,
    input  spi_word_t word,
    output logic      frame_valid,
    output spi_byte_t frame_cmd,
    output spi_byte_t frame_data,
    output logic      read_pending
);
    // Latch the word and raise the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_valid <= 1'b0;
            frame_cmd   <= '0;
            frame_data  <= '0;
        end else begin
            frame_valid <= cs_rise;
            if (cs_rise) begin
                frame_cmd  <= word.cmd;
                frame_data <= word.data;
            end
        end
    end

    // Arm the readback load from the flag, consume it at the next frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)       read_pending <= 1'b0;
        else if (cs_rise) read_pending <= word.cmd[READ_FLAG_BIT];
        else if (cs_fall) read_pending <= 1'b0;
    end
endmodule

// File: rtl/spi_chain_slave.sv
// Top of the chainable serial slave: synchronisers, edge detection,
// shifter and frame latch. Assumes clk is several times faster than sclk.
module spi_chain_slave
    import spi_chain_pkg::*;
#(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned READ_FLAG_BIT = SPI_BYTE_W - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  din,
    input  logic [SPI_BYTE_W-1:0] rd_byte,
    output logic                  dout,
    output logic                  frame_valid,
    output logic [SPI_BYTE_W-1:0] frame_cmd,
    output logic [SPI_BYTE_W-1:0] frame_data
);
    localparam int unsigned LANE_SCLK = 0;
    localparam int unsigned LANE_CS   = 1;
    localparam int unsigned LANE_DIN  = 2;

    logic [2:0] lvl;
    logic [1:0] rise;
    logic [1:0] fall;
    spi_word_t  word;
    logic       read_pending;
    logic       cs_active;

    sync_chain #(
        .LANES     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b010)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({din, cs_n, sclk}),
        .sync_out (lvl)
    );

    edge_detect #(
        .LANES     (2),
        .RESET_VAL (2'b10)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (lvl[LANE_CS:LANE_SCLK]),
        .rise  (rise),
        .fall  (fall)
    );

    assign cs_active = ~lvl[LANE_CS];

    shift_core u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .sclk_rise (rise[LANE_SCLK]),
        .sclk_fall (fall[LANE_SCLK]),
        .cs_fall   (fall[LANE_CS]),
        .din_s     (lvl[LANE_DIN]),
        .load_en   (read_pending),
        .load_byte (rd_byte),
        .word      (word),
        .dout      (dout)
    );

    frame_latch #(
        .READ_FLAG_BIT (READ_FLAG_BIT)
    ) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_rise      (rise[LANE_CS]),
        .cs_fall      (fall[LANE_CS]),
        .word         (word),
        .frame_valid  (frame_valid),
        .frame_cmd    (frame_cmd),
        .frame_data   (frame_data),
        .read_pending (read_pending)
    );
endmodule

// File: rtl/spi_chain_slave_chk.sv
// Temporal checks on the serial slave ports, bound into the top.
// Assumes chip select stays high for several clk cycles between frames.
module spi_chain_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       dout,
    input logic       frame_valid,
    input logic [7:0] frame_cmd,
    input logic [7:0] frame_data
);
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    assert_strobe_cs_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> cs_n);

    assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> $stable(frame_cmd));

    assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> $stable(frame_data));

    assert_dout_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4))
        |-> $stable(dout));
endmodule

bind spi_chain_slave spi_chain_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .dout        (dout),
    .frame_valid (frame_valid),
    .frame_cmd   (frame_cmd),
    .frame_data  (frame_data)
);

// File: tb/spi_chain_slave_tb.sv
// Self-checking bench: directed corner frames plus seeded random frames.
module spi_chain_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       din = 1'b0;
    logic [7:0] rd_byte = 8'h00;
    logic       dout;
    logic       frame_valid;
    logic [7:0] frame_cmd;
    logic [7:0] frame_data;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] model = 16'h0000;
    logic        pend  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_chain_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .rd_byte(rd_byte), .dout(dout), .frame_valid(frame_valid),
        .frame_cmd(frame_cmd), .frame_data(frame_data)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] shift_in(input logic [15:0] w, input logic b);
        return {w[14:0], b};
    endfunction

    // One serial bit: R2 shift on rise, R6 dout after fall.
    task automatic send_bit(input logic b);
        din = b;
        idle(HALF_SCLK);
        sclk = 1'b1;
        model = shift_in(model, b);
        idle(HALF_SCLK);
        sclk = 1'b0;
        idle(HALF_SCLK);
        check("R6 dout", {31'd0, dout}, {31'd0, model[15]});
    endtask

    // A frame of nbits taken MSB-first from bits[nbits-1:0]; R4/R5/R8 latch check.
    task automatic send_frame(input int nbits, input logic [31:0] bits);
        int pulses;
        logic [7:0] cap_c, cap_d;
        cs_n = 1'b0;
        if (pend) model[7:0] = rd_byte;
        idle(HALF_SCLK);
        for (int i = nbits - 1; i >= 0; i--) send_bit(bits[i]);
        cs_n = 1'b1;
        pulses = 0; cap_c = 8'h00; cap_d = 8'h00;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); #1;
            if (frame_valid) begin
                pulses++;
                cap_c = frame_cmd;
                cap_d = frame_data;
            end
        end
        check("R4 strobe count", pulses, 1);
        check("R4 R5 R8 cmd", {24'd0, cap_c}, {24'd0, model[15:8]});
        check("R4 R5 R8 data", {24'd0, cap_d}, {24'd0, model[7:0]});
        pend = model[15];
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed_dummy;
        logic hold;
        seed_dummy = $urandom(32'h5EED_0017);
        idle(4);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 dout", {31'd0, dout}, 0);
        check("R1 frame_valid", {31'd0, frame_valid}, 0);
        check("R1 cmd", {24'd0, frame_cmd}, 0);
        check("R1 data", {24'd0, frame_data}, 0);
        @(negedge clk);

        // R2: plain 16-bit frame, read flag clear.
        send_frame(16, 32'h0000_1234);
        // R5: long frame keeps only the last 16 bits.
        send_frame(20, 32'h000F_ABCD);
        // R5: short frame shifts stale bits upward.
        send_frame(5, 32'h0000_0015);
        // R8: read-flagged command, then an 8-bit frame brings rd_byte into cmd.
        send_frame(16, 32'h0000_8566);
        rd_byte = 8'hA5;
        send_frame(8, 32'h0000_003C);
        // R8: flag set again (0xA5), full frame pushes the loaded byte out on dout.
        rd_byte = 8'h5A;
        send_frame(16, 32'h0000_0F0F);

        // R3 R7: activity while cs_n high leaves dout and the word alone.
        hold = dout;
        for (int i = 0; i < 6; i++) begin
            din = $urandom_range(0, 1);
            idle(HALF_SCLK); sclk = 1'b1;
            idle(HALF_SCLK); sclk = 1'b0;
            idle(HALF_SCLK);
            check("R3 R7 dout idle", {31'd0, dout}, {31'd0, hold});
        end
        send_frame(0, 32'h0);

        // Random frames of 0..24 bits with random readback bytes.
        for (int f = 0; f < 40; f++) begin
            rd_byte = 8'($urandom);
            send_frame($urandom_range(0, 24), $urandom);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule